// File: doc/BRIEF.md
# Exception Vector Selector and Stack Frame Writer

This block decides which exception a processor core must take when one or more causes are reported in a cycle. The causes are a failed check on a return-from-exception, an illegal instruction word or extension word, an instruction word from one of the two reserved emulation groups, and a taken breakpoint. The block picks one vector number by fixed priority and reports it together with its table offset, which is four times the vector.

After choosing, the block pushes the exception frame onto the supervisor stack one 16-bit word at a time. It uses a simple valid/ready write port and moves the stack address down by two bytes per word. A breakpoint frame has six words. Every other cause gets a four-word frame. When the final word is accepted, the block raises a one-cycle done pulse. Causes that arrive while a frame is being written are dropped. Whether a normal opcode is legal is decided by an external decoder, which drives a single legal flag.

Top module: `exc_entry_seq`

## Requirements
- R1: During and after reset, with no cause present: stkWrEn is 0, frameDone is 0, vecNum is 0 and vecOffset is 0.
- R2: With instrValid high, an instruction word whose bits 15..12 equal 4'b1010 selects vector 10 (offset 0x28). instrLegal is ignored for such a word.
- R3: With instrValid high, an instruction word whose bits 15..12 equal 4'b1111 selects vector 11 (offset 0x2C). instrLegal is ignored for such a word.
- R4: Vector 4 (offset 0x10) is selected in either of two cases. The first is a valid instruction word outside those two groups with instrLegal low. The second is a valid extension word whose bits 5..4 are 2'b00 or whose bits 3..0 are not 4'b0000. A valid extension word that passes both tests, together with a legal word, starts no frame.
- R5: fmtErr selects vector 14 (offset 0x38). Its frame saves curPc, which is the address of the return instruction.
- R6: bkptTaken selects vector 12 (offset 0x30). Its six words are written in this order: curPc[15:0], curPc[31:16], the vector word, nextPc[15:0], nextPc[31:16], statusReg.
- R7: Every other frame has four words, written in this order: the vector word, curPc[15:0], curPc[31:16], statusReg. The vector word is vecOffset zero-extended to 16 bits.
- R8: Word k of a frame (k starting at 0) is presented at address spIn - 2*(k+1). The spIn, curPc, nextPc and statusReg values used are those sampled in the accepting cycle. A word advances only on a cycle where stkWrEn and stkWrReady are both high. Otherwise address and data hold.
- R9: frameDone is high for exactly one cycle, the cycle right after the final handshake. stkWrEn is already low in that cycle.
- R10: When causes coincide, the priority is: format error, then illegal, then the two emulation groups, then breakpoint.
- R11: A cause presented while stkWrEn is high is ignored. vecNum and the frame being written do not change. A cause is accepted in any cycle where stkWrEn is low, and stkWrEn rises in the next cycle.
- R12: vecNum and vecOffset update in the cycle after acceptance and hold until the next acceptance. vecOffset always equals vecNum times four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | instrWord is valid this cycle |
| instrWord | input | 16 | Fetched first instruction word |
| instrLegal | input | 1 | External decoder verdict for instrWord |
| extValid | input | 1 | extWord is an indexed-mode extension word |
| extWord | input | 16 | Indexed-mode extension word |
| fmtErr | input | 1 | Return-from-exception format/version check failed |
| bkptTaken | input | 1 | Pending breakpoint acknowledged with error |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Address of the next instruction |
| statusReg | input | 16 | Status register copy |
| spIn | input | 32 | Supervisor stack pointer before the frame |
| stkWrEn | output | 1 | Stack write request; high while a frame is in progress |
| stkWrAddr | output | 32 | Byte address of the current stack word |
| stkWrData | output | 16 | Current stack word |
| stkWrReady | input | 1 | Stack port accepts the word this cycle |
| vecNum | output | 8 | Selected vector number |
| vecOffset | output | 10 | Vector table offset (vecNum * 4) |
| frameDone | output | 1 | One-cycle pulse after the last word |

## Verification
Two kinds of collision matter. One is between classification and prioritisation: several causes raised in one cycle, for example all four together, a reserved-group word with a breakpoint, or a bad extension word with a reserved-group word. The bench checks that the vector of the higher-ranked cause appears one cycle later and that the frame has the matching length. The other is between acceptance and sequencing: a format error raised while a frame is half written, with the write port stalled at random. The bench compares every cycle against a behavioural model that holds the expected words in a queue. A dropped cause must leave vecNum, the address and the data exactly as the model predicts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W    = 8;
  localparam int IDX_W    = 3;
  localparam int LEN_LONG = 6;
  localparam int LEN_SHORT = 4;

  localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [VEC_W-1:0] VEC_LINE_A  = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F  = 8'd11;
  localparam logic [VEC_W-1:0] VEC_BKPT    = 8'd12;
  localparam logic [VEC_W-1:0] VEC_FORMAT  = 8'd14;

  typedef struct packed {
    logic             load;
    logic             fire;
    logic [VEC_W-1:0] vec;
    logic [IDX_W-1:0] idx;
  } excStrobe_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              instrLegal,
  input  logic              extValid,
  input  logic [WORD_W-1:0] extWord,
  input  logic              fmtErr,
  input  logic              bkptTaken,
  input  logic              stkWrReady,
  output excStrobe_t        st,
  output logic              busy,
  output logic              done
);
  logic lineA, lineF, extBad, illegal, anyCause, lastWord;
  logic [VEC_W-1:0] vecPick;
  logic [IDX_W-1:0] idxR, lastIdxR;

  assign lineA   = instrValid && (instrWord[WORD_W-1 -: 4] == 4'b1010);
  assign lineF   = instrValid && (instrWord[WORD_W-1 -: 4] == 4'b1111);
  assign extBad  = extValid && ((extWord[5:4] == 2'b00) || (extWord[3:0] != 4'b0000));
  assign illegal = extBad || (instrValid && !lineA && !lineF && !instrLegal);

  always_comb begin
    anyCause = 1'b1;
    vecPick  = '0;
    if (fmtErr)         vecPick = VEC_FORMAT;
    else if (illegal)   vecPick = VEC_ILLEGAL;
    else if (lineA)     vecPick = VEC_LINE_A;
    else if (lineF)     vecPick = VEC_LINE_F;
    else if (bkptTaken) vecPick = VEC_BKPT;
    else                anyCause = 1'b0;
  end

  assign lastWord = (idxR == lastIdxR);

  always_comb begin
    st.load = !busy && anyCause;
    st.fire = busy && stkWrReady;
    st.vec  = vecPick;
    st.idx  = idxR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      idxR     <= '0;
      lastIdxR <= '0;
    end else begin
      done <= 1'b0;
      if (st.load) begin
        busy     <= 1'b1;
        idxR     <= '0;
        lastIdxR <= (vecPick == VEC_BKPT) ? IDX_W'(LEN_LONG - 1) : IDX_W'(LEN_SHORT - 1);
      end else if (st.fire) begin
        if (lastWord) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idxR <= idxR + 1'b1;
        end
      end
    end
  end

  // R9: the word index never passes the frame length
  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (idxR <= lastIdxR));
  // R11: an open frame stays open until its last handshake
  a_r11_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(stkWrReady && lastWord)) |=> busy);
endmodule

// File: rtl/exc_dp.sv
module exc_dp
  import exc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  excStrobe_t        st,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [WORD_W-1:0] statusReg,
  input  logic [ADDR_W-1:0] spIn,
  output logic [ADDR_W-1:0] stkWrAddr,
  output logic [WORD_W-1:0] stkWrData,
  output logic [VEC_W-1:0]  vecNum,
  output logic [VEC_W+1:0]  vecOffset
);
  localparam int OFF_W = VEC_W + 2;
  localparam int HALF  = ADDR_W / 2;

  logic [VEC_W-1:0]  vecR;
  logic [ADDR_W-1:0] pcR, npR, spR;
  logic [WORD_W-1:0] srR, vecWord;
  logic              isBkpt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecR <= '0;
      pcR  <= '0;
      npR  <= '0;
      srR  <= '0;
      spR  <= '0;
    end else if (st.load) begin
      vecR <= st.vec;
      pcR  <= curPc;
      npR  <= nextPc;
      srR  <= statusReg;
      spR  <= spIn;
    end else if (st.fire) begin
      spR  <= spR - ADDR_W'(2);
    end
  end

  assign vecNum    = vecR;
  assign vecOffset = {vecR, 2'b00};
  assign vecWord   = {{(WORD_W-OFF_W){1'b0}}, vecOffset};
  assign isBkpt    = (vecR == VEC_BKPT);
  assign stkWrAddr = spR - ADDR_W'(2);

  always_comb begin
    stkWrData = '0;
    if (isBkpt) begin
      case (st.idx)
        3'd0: stkWrData = pcR[HALF-1:0];
        3'd1: stkWrData = pcR[ADDR_W-1:HALF];
        3'd2: stkWrData = vecWord;
        3'd3: stkWrData = npR[HALF-1:0];
        3'd4: stkWrData = npR[ADDR_W-1:HALF];
        default: stkWrData = srR;
      endcase
    end else begin
      case (st.idx)
        3'd0: stkWrData = vecWord;
        3'd1: stkWrData = pcR[HALF-1:0];
        3'd2: stkWrData = pcR[ADDR_W-1:HALF];
        default: stkWrData = srR;
      endcase
    end
  end

  // R8: each accepted word moves the stack address down by one word
  a_r8_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && !st.load) |=> (stkWrAddr == $past(stkWrAddr) - ADDR_W'(2)));
  // R12: the vector is only replaced on a load
  a_r12_vec_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.load |=> $stable(vecNum));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              instrLegal,
  input  logic              extValid,
  input  logic [WORD_W-1:0] extWord,
  input  logic              fmtErr,
  input  logic              bkptTaken,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [WORD_W-1:0] statusReg,
  input  logic [ADDR_W-1:0] spIn,
  output logic              stkWrEn,
  output logic [ADDR_W-1:0] stkWrAddr,
  output logic [WORD_W-1:0] stkWrData,
  input  logic              stkWrReady,
  output logic [VEC_W-1:0]  vecNum,
  output logic [VEC_W+1:0]  vecOffset,
  output logic              frameDone
);
  excStrobe_t st;
  logic busy;

  exc_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrLegal(instrLegal), .extValid(extValid), .extWord(extWord),
    .fmtErr(fmtErr), .bkptTaken(bkptTaken), .stkWrReady(stkWrReady),
    .st(st), .busy(busy), .done(frameDone)
  );

  exc_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .curPc(curPc), .nextPc(nextPc),
    .statusReg(statusReg), .spIn(spIn), .stkWrAddr(stkWrAddr),
    .stkWrData(stkWrData), .vecNum(vecNum), .vecOffset(vecOffset)
  );

  assign stkWrEn = busy;

  // R5: a format error seen while idle opens a frame with vector 14
  a_r5_format_vec: assert property (@(posedge clk) disable iff (!rstN)
    (!stkWrEn && fmtErr) |=> (stkWrEn && vecNum == 8'd14));
  // R8: a stalled word holds address and data
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stkWrEn && !stkWrReady) |=> (stkWrEn && $stable(stkWrAddr) && $stable(stkWrData)));
  // R9: done is a single-cycle pulse and never overlaps a write
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (!stkWrEn && $past(stkWrEn)) ##1 !frameDone);
  // R11: causes arriving mid-frame leave the vector untouched
  a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    stkWrEn |=> $stable(vecNum));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 0, instrLegal = 1, extValid = 0, fmtErr = 0, bkptTaken = 0, stkWrReady = 1;
  logic [15:0] instrWord = 0, extWord = 0, statusReg = 0;
  logic [31:0] curPc = 0, nextPc = 0, spIn = 0;
  logic stkWrEn, frameDone;
  logic [31:0] stkWrAddr;
  logic [15:0] stkWrData;
  logic [7:0] vecNum;
  logic [9:0] vecOffset;

  int tests = 0, fails = 0;
  bit randReady = 0, finished = 0;

  // model state
  bit busyM = 0, doneM = 0;
  int vecM = 0;
  logic [47:0] q[$];

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrLegal(instrLegal), .extValid(extValid), .extWord(extWord),
    .fmtErr(fmtErr), .bkptTaken(bkptTaken), .curPc(curPc), .nextPc(nextPc),
    .statusReg(statusReg), .spIn(spIn), .stkWrEn(stkWrEn), .stkWrAddr(stkWrAddr),
    .stkWrData(stkWrData), .stkWrReady(stkWrReady), .vecNum(vecNum),
    .vecOffset(vecOffset), .frameDone(frameDone)
  );

  function automatic int pickVec();
    bit grpA = instrValid && instrWord[15:12] == 4'hA;
    bit grpF = instrValid && instrWord[15:12] == 4'hF;
    bit badExt = extValid && (extWord[5:4] == 0 || extWord[3:0] != 0);
    if (fmtErr) return 14;
    if (badExt || (instrValid && !grpA && !grpF && !instrLegal)) return 4;
    if (grpA) return 10;
    if (grpF) return 11;
    if (bkptTaken) return 12;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      busyM = 0; doneM = 0; vecM = 0; q.delete();
    end else begin
      doneM = 0;
      if (busyM) begin
        if (stkWrReady) begin
          void'(q.pop_front());
          if (q.size() == 0) begin busyM = 0; doneM = 1; end
        end
      end else if (pickVec() >= 0) begin
        logic [15:0] vw;
        logic [15:0] words[$];
        vecM = pickVec();
        vw = 16'(vecM * 4);
        if (vecM == 12)
          words = '{curPc[15:0], curPc[31:16], vw, nextPc[15:0], nextPc[31:16], statusReg};
        else
          words = '{vw, curPc[15:0], curPc[31:16], statusReg};
        foreach (words[k]) q.push_back({spIn - 32'(2 * (k + 1)), words[k]});
        busyM = 1;
      end
    end
  end

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R11 stkWrEn", stkWrEn == busyM, stkWrEn, busyM);
    check("R9 frameDone", frameDone == doneM, frameDone, doneM);
    check("R12 vecNum", vecNum == 8'(vecM), vecNum, vecM);
    check("R12 vecOffset", vecOffset == 10'(vecM * 4), vecOffset, vecM * 4);
    if (busyM && stkWrEn) begin
      check("R8 stkWrAddr", stkWrAddr == q[0][47:16], stkWrAddr, q[0][47:16]);
      check("R7/R6 stkWrData", stkWrData == q[0][15:0], stkWrData, q[0][15:0]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rstN) compareAll();
    stkWrReady = randReady ? 1'($urandom_range(0, 2) != 0) : 1'b1;
  endtask

  task automatic clearCauses();
    instrValid = 0; extValid = 0; fmtErr = 0; bkptTaken = 0; instrLegal = 1;
  endtask

  task automatic setCtx();
    curPc = $urandom; nextPc = $urandom; statusReg = 16'($urandom);
    spIn = {$urandom_range(1, 65535), 16'h0} + 32'h100;
  endtask

  // drive causes for one edge and check the vector in the following cycle
  task automatic fire(input string req, input int expVec);
    setCtx();
    step();
    clearCauses();
    check(req, vecNum == 8'(expVec) && stkWrEn, vecNum, expVec);
    check(req, vecOffset == 10'(expVec * 4), vecOffset, expVec * 4);
  endtask

  task automatic drain();
    int guard = 0;
    while (stkWrEn && guard < 100) begin step(); guard++; end
    step();
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1 reset wr", stkWrEn == 0 && frameDone == 0, stkWrEn, 0);
      check("R1 reset vec", vecNum == 0 && vecOffset == 0, vecNum, 0);
    end
    rstN = 1;
    step();
    check("R1 idle", stkWrEn == 0 && vecNum == 0, stkWrEn, 0);

    // R2: reserved group A, decoder flag ignored
    instrValid = 1; instrWord = 16'hA123; instrLegal = 0;
    fire("R2 line A", 10); drain();
    // R3: reserved group F
    instrValid = 1; instrWord = 16'hF2C0; instrLegal = 1;
    fire("R3 line F", 11); drain();
    // R4: decoder says illegal
    instrValid = 1; instrWord = 16'h4E71; instrLegal = 0;
    fire("R4 decoder", 4); drain();
    // R4: extension word with bits 5..4 zero
    instrValid = 1; instrWord = 16'h3030; extValid = 1; extWord = 16'h0800;
    fire("R4 ext scale", 4); drain();
    // R4: extension word with low bits set
    extValid = 1; extWord = 16'h0013;
    fire("R4 ext low", 4); drain();
    // R4: a good extension word starts nothing
    instrValid = 1; instrWord = 16'h3030; extValid = 1; extWord = 16'h0010;
    step(); clearCauses(); step();
    check("R4 good ext no frame", stkWrEn == 0 && vecNum == 8'd4, vecNum, 4);
    // R5: format error
    fmtErr = 1;
    fire("R5 format", 14); drain();
    // R6: breakpoint with random stalls
    randReady = 1;
    bkptTaken = 1;
    fire("R6 bkpt", 12); drain();
    // R10: everything at once
    fmtErr = 1; bkptTaken = 1; instrValid = 1; instrWord = 16'hA000; extValid = 1; extWord = 16'h0000;
    fire("R10 all", 14); drain();
    instrValid = 1; instrWord = 16'hAFFF; bkptTaken = 1;
    fire("R10 lineA over bkpt", 10); drain();
    instrValid = 1; instrWord = 16'hF000; extValid = 1; extWord = 16'h0001;
    fire("R10 illegal over lineF", 4); drain();
    // R11: cause while a frame is open
    bkptTaken = 1;
    fire("R11 start", 12);
    step(); fmtErr = 1; step(); step(); clearCauses();
    check("R11 still bkpt", vecNum == 8'd12, vecNum, 12);
    drain();
    // mixed random traffic
    for (int n = 0; n < 40; n++) begin
      int sel = $urandom_range(0, 3);
      case (sel)
        0: fmtErr = 1;
        1: bkptTaken = 1;
        2: begin instrValid = 1; instrWord = 16'($urandom); instrLegal = 1'($urandom); end
        default: begin extValid = 1; extWord = 16'($urandom); end
      endcase
      setCtx();
      step(); clearCauses();
      repeat ($urandom_range(0, 8)) step();
    end
    drain();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule